// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block gathers interrupt requests from fifteen sources and offers one at a time to a processor core. The sources are two active-low external pins, two timer overflows, four capture inputs, three compare events, a second-timer overflow, an analog-conversion-done event, a CAN controller event and a serial port event. Each source has its own enable bit and its own priority bit. A global enable gates all of them, and a DMA-busy input holds off every grant while it is asserted.

The external pins can run in level mode or falling-edge mode. Each capture input can catch rising edges, falling edges or both. The block latches these edge events itself. The other peripheral lines are taken as level flags that the peripheral owns.

The request leaves the block as a valid/ready pair carrying a 4-bit vector and a priority-level bit. The request is recomputed every cycle from the pending state. While ready is low, valid may drop, or the vector may change when a better candidate appears. The CPU takes exactly the vector shown in the cycle where valid and ready are both high at a rising clock edge. Taking a request marks its level in service, and a return strobe from the CPU ends the innermost handler.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Vector index equals source index. The index map is: 0 external pin A, 1 timer 0, 2 external pin B, 3 timer 1, 4..7 capture 0..3, 8..10 compare 0..2, 11 second-timer overflow, 12 conversion done, 13 CAN, 14 serial. On `periph_irq`, bits 0..1 are the timers, bits 2..4 the compares, then 5 overflow, 6 conversion, 7 CAN and 8 serial.
- R2: A source whose `src_enable` bit is 0 never produces a request.
- R3: While `global_enable` is 0, `irq_valid` stays 0.
- R4: A `src_high_prio` bit of 1 makes a source high level. With nothing in service, any pending high source wins over every low source, and `irq_high` shows the level of the offered request.
- R5: Among pending sources of one level, the lowest index wins.
- R6: A low request is offered only while nothing is in service. A high request is offered while only the low level is in service.
- R7: No request is offered while the high level is in service.
- R8: In level mode (`ext_edge_mode`=0), an external pin requests in the same cycle it is low and stops when it goes high.
- R9: In edge mode, a falling pin edge sets a flag that is visible after the next rising clock edge and survives the pin returning high. The flag is cleared when its vector is accepted.
- R10: A capture input sets its flag on a rising edge when `cap_rise_en` is set, and on a falling edge when `cap_fall_en` is set. The flag is visible after the next clock edge and is cleared when its vector is accepted.
- R11: While `dma_busy` is 1, `irq_valid` stays 0. Pending flags are kept and are offered once `dma_busy` returns to 0.
- R12: When `irq_valid` and `irq_ready` are both 1 at a rising edge, the in-service bit of the offered level (`in_service[1]` high, `in_service[0]` low) is set after that edge.
- R13: A `reti_strobe` clears `in_service[1]` if it is set, and clears `in_service[0]` otherwise.
- R14: After reset, `irq_valid`=0, `in_service`=0, and all latched flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | External request pins A (bit 0) and B (bit 1), active low |
| ext_edge_mode | input | 2 | Per pin: 1 selects falling-edge mode, 0 selects level mode |
| cap_in | input | 4 | Capture input lines |
| cap_rise_en | input | 4 | Per capture input: enable rising-edge detection |
| cap_fall_en | input | 4 | Per capture input: enable falling-edge detection |
| periph_irq | input | 9 | Level request lines from the peripherals |
| src_enable | input | 15 | Per-source enable, indexed by vector |
| src_high_prio | input | 15 | Per-source level, 1 selects high |
| global_enable | input | 1 | Master gate for all requests |
| dma_busy | input | 1 | Holds off all grants while set |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | CPU accepts the offered request |
| irq_vec | output | 4 | Vector index of the offered request |
| irq_high | output | 1 | Offered request is high level |
| reti_strobe | input | 1 | Return from the innermost handler |
| in_service | output | 2 | In-service bits, bit 1 high, bit 0 low |

## Verification
`irq_valid`, `irq_vec` and `irq_high` are combinational from the enables, level lines, latched flags and in-service bits. A change on a level line or a control bit therefore shows in the same cycle. An edge on a pin or capture input shows only after one rising edge. `in_service` and flag clearing follow a handshake or return strobe by one rising edge. The bench drives every input just after a falling edge and samples half a period later, before the next rising edge. A cycle-stepped reference model predicts the outputs from the stimulus of the current cycle and the state built up through the previous rising edges. Directed checks compare against hand-worked values at those same sample points.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned NSRC   = 15;
  localparam int unsigned VEC_W  = $clog2(NSRC);
  localparam int unsigned NEXT   = 2;
  localparam int unsigned NCAP   = 4;
  localparam int unsigned NPER   = 9;
  localparam int unsigned NLVL   = 2;

  // source index map, also the vector presented to the CPU
  localparam int unsigned SRC_EXT_A = 0;
  localparam int unsigned SRC_TMR0  = 1;
  localparam int unsigned SRC_EXT_B = 2;
  localparam int unsigned SRC_TMR1  = 3;
  localparam int unsigned SRC_CAP0  = 4;
  localparam int unsigned SRC_CMP0  = 8;
  localparam int unsigned NCMP      = 3;
  localparam int unsigned SRC_TAIL  = 11;   // overflow, conversion, CAN, serial
  localparam int unsigned NTAIL     = 4;

  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} irq_lvl_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int unsigned W         = 4,
  parameter logic        PREV_INIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] keep,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  assign hit = (rise_en & ~prev_q & line) | (fall_en & prev_q & ~line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= {W{PREV_INIT}};
      flag   <= '0;
    end else begin
      prev_q <= line;
      // a new event in the acknowledge cycle wins over the clear
      flag   <= keep & ((flag & ~clr) | hit);
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N  = 15,
  parameter int unsigned VW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [VW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    // scan downward so the lowest set index is the one left standing
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = VW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NEXT-1:0]         ext_pin_n,
  input  logic [NEXT-1:0]         ext_edge_mode,
  input  logic [NCAP-1:0]         cap_in,
  input  logic [NCAP-1:0]         cap_rise_en,
  input  logic [NCAP-1:0]         cap_fall_en,
  input  logic [NPER-1:0]         periph_irq,
  input  logic [NSRC-1:0]         src_enable,
  input  logic [NSRC-1:0]         src_high_prio,
  input  logic                    global_enable,
  input  logic                    dma_busy,
  output logic                    irq_valid,
  input  logic                    irq_ready,
  output logic [VEC_W-1:0]        irq_vec,
  output logic                    irq_high,
  input  logic                    reti_strobe,
  output logic [NLVL-1:0]         in_service
);
  logic [NSRC-1:0]  pend, act, hi_cand, lo_cand, clr_vec;
  logic [NEXT-1:0]  ext_flag, ext_clr;
  logic [NCAP-1:0]  cap_flag, cap_clr;
  logic             gate, grant, hi_found, lo_found;
  logic [VEC_W-1:0] hi_idx, lo_idx;
  logic [NLVL-1:0]  isr_q, isr_d;

  assign grant   = irq_valid & irq_ready;
  assign clr_vec = grant ? (NSRC'(1) << irq_vec) : '0;
  assign ext_clr = {clr_vec[SRC_EXT_B], clr_vec[SRC_EXT_A]};
  assign cap_clr = clr_vec[SRC_CAP0 +: NCAP];

  irq_edge_latch #(.W(NEXT), .PREV_INIT(1'b1)) u_ext (
    .clk(clk), .rst_n(rst_n), .line(ext_pin_n),
    .rise_en('0), .fall_en({NEXT{1'b1}}), .keep(ext_edge_mode),
    .clr(ext_clr), .flag(ext_flag)
  );

  irq_edge_latch #(.W(NCAP), .PREV_INIT(1'b0)) u_cap (
    .clk(clk), .rst_n(rst_n), .line(cap_in),
    .rise_en(cap_rise_en), .fall_en(cap_fall_en), .keep({NCAP{1'b1}}),
    .clr(cap_clr), .flag(cap_flag)
  );

  // assemble pending vector in vector order
  always_comb begin
    pend            = '0;
    pend[SRC_EXT_A] = ext_edge_mode[0] ? ext_flag[0] : ~ext_pin_n[0];
    pend[SRC_EXT_B] = ext_edge_mode[1] ? ext_flag[1] : ~ext_pin_n[1];
    pend[SRC_TMR0]  = periph_irq[0];
    pend[SRC_TMR1]  = periph_irq[1];
    pend[SRC_CAP0 +: NCAP] = cap_flag;
    pend[SRC_CMP0 +: NCMP] = periph_irq[2 +: NCMP];
    pend[SRC_TAIL +: NTAIL] = periph_irq[2 + NCMP +: NTAIL];
  end

  assign gate    = global_enable & ~dma_busy;
  assign act     = pend & src_enable & {NSRC{gate}};
  assign hi_cand = act & src_high_prio  & {NSRC{~isr_q[LVL_HIGH]}};
  assign lo_cand = act & ~src_high_prio & {NSRC{isr_q == '0}};

  irq_pick #(.N(NSRC), .VW(VEC_W)) u_pick_hi (
    .cand(hi_cand), .found(hi_found), .idx(hi_idx)
  );
  irq_pick #(.N(NSRC), .VW(VEC_W)) u_pick_lo (
    .cand(lo_cand), .found(lo_found), .idx(lo_idx)
  );

  assign irq_valid = hi_found | lo_found;
  assign irq_vec   = hi_found ? hi_idx : lo_idx;
  assign irq_high  = hi_found;

  always_comb begin
    isr_d = isr_q;
    if (reti_strobe) begin
      if (isr_q[LVL_HIGH]) isr_d[LVL_HIGH] = 1'b0;
      else                 isr_d[LVL_LOW]  = 1'b0;
    end
    if (grant) isr_d[irq_high] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign in_service = isr_q;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
  import irq_nest_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             global_enable,
  input logic             dma_busy,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_high,
  input logic             reti_strobe,
  input logic [NLVL-1:0]  in_service
);
  p_vec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vec < VEC_W'(NSRC)));

  p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !global_enable |-> !irq_valid);

  p_low_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_high) |-> (in_service == 2'b00));

  p_no_hi_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !in_service[1]);

  p_dma_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy |-> !irq_valid);

  p_take_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && irq_high) |=> in_service[1]);

  p_take_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !irq_high) |=> in_service[0]);

  p_ret_high_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_strobe && in_service[1] && !(irq_valid && irq_ready)) |=> !in_service[1]);

  p_ret_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_strobe && in_service == 2'b01 && !(irq_valid && irq_ready)) |=> (in_service == 2'b00));
endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
  .clk(clk), .rst_n(rst_n), .global_enable(global_enable), .dma_busy(dma_busy),
  .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vec(irq_vec),
  .irq_high(irq_high), .reti_strobe(reti_strobe), .in_service(in_service)
);

// File: tb/sim_irq_nest_ctrl.sv
`timescale 1ns/100ps
module sim_irq_nest_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ext_pin_n, ext_edge_mode;
  logic [3:0] cap_in, cap_rise_en, cap_fall_en;
  logic [8:0] periph_irq;
  logic [14:0] src_enable, src_high_prio;
  logic global_enable, dma_busy, irq_ready, reti_strobe;
  logic irq_valid, irq_high;
  logic [3:0] irq_vec;
  logic [1:0] in_service;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [1:0] m_ext_flag, m_ext_prev, m_isr;
  logic [3:0] m_cap_flag, m_cap_prev;

  always #2 clk = ~clk;   // 250 MHz

  irq_nest_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
    .cap_in(cap_in), .cap_rise_en(cap_rise_en), .cap_fall_en(cap_fall_en),
    .periph_irq(periph_irq), .src_enable(src_enable), .src_high_prio(src_high_prio),
    .global_enable(global_enable), .dma_busy(dma_busy), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vec(irq_vec), .irq_high(irq_high),
    .reti_strobe(reti_strobe), .in_service(in_service)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [14:0] m_pend();
    logic [14:0] p;
    p[0] = ext_edge_mode[0] ? m_ext_flag[0] : ~ext_pin_n[0];
    p[2] = ext_edge_mode[1] ? m_ext_flag[1] : ~ext_pin_n[1];
    p[1] = periph_irq[0];
    p[3] = periph_irq[1];
    p[7:4] = m_cap_flag;
    p[14:8] = periph_irq[8:2];
    return p;
  endfunction

  // returns {valid, high, vec}
  function automatic logic [5:0] m_out();
    logic [14:0] a;
    a = m_pend() & src_enable;
    if (!global_enable || dma_busy) return 6'd0;
    if (!m_isr[1])
      for (int i = 0; i < 15; i++)
        if (a[i] && src_high_prio[i]) return {1'b1, 1'b1, 4'(i)};
    if (m_isr == 2'b00)
      for (int i = 0; i < 15; i++)
        if (a[i] && !src_high_prio[i]) return {1'b1, 1'b0, 4'(i)};
    return 6'd0;
  endfunction

  task automatic settle();
    #0.5;
  endtask

  // compare against model, then step model over the coming rising edge
  task automatic adv(input string tag);
    logic [5:0] e;
    logic [14:0] clr;
    logic [1:0] ef;
    logic [3:0] cs;
    e = m_out();
    chk({tag, " valid"}, {7'd0, irq_valid}, {7'd0, e[5]});
    if (e[5]) begin
      chk({tag, " vec"}, {4'd0, irq_vec}, {4'd0, e[3:0]});
      chk({tag, " level"}, {7'd0, irq_high}, {7'd0, e[4]});
    end
    chk({tag, " in_service"}, {6'd0, in_service}, {6'd0, m_isr});
    clr = (e[5] && irq_ready) ? (15'd1 << e[3:0]) : 15'd0;
    ef = m_ext_prev & ~ext_pin_n;
    m_ext_flag = ext_edge_mode & ((m_ext_flag & ~{clr[2], clr[0]}) | ef);
    m_ext_prev = ext_pin_n;
    cs = (cap_rise_en & ~m_cap_prev & cap_in) | (cap_fall_en & m_cap_prev & ~cap_in);
    m_cap_flag = (m_cap_flag & ~clr[7:4]) | cs;
    m_cap_prev = cap_in;
    if (reti_strobe) begin
      if (m_isr[1]) m_isr[1] = 1'b0; else m_isr[0] = 1'b0;
    end
    if (e[5] && irq_ready) m_isr[e[4]] = 1'b1;
    @(negedge clk);
  endtask

  task automatic cyc(input string tag);
    settle();
    adv(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    ext_pin_n = 2'b11; ext_edge_mode = 2'b00;
    cap_in = 4'h0; cap_rise_en = 4'h0; cap_fall_en = 4'h0;
    periph_irq = '0; src_enable = '1; src_high_prio = '0;
    global_enable = 1'b1; dma_busy = 1'b0; irq_ready = 1'b0; reti_strobe = 1'b0;
    m_ext_flag = 0; m_ext_prev = 2'b11; m_isr = 0; m_cap_flag = 0; m_cap_prev = 0;
    repeat (3) @(negedge clk);
    chk("R14 valid in reset", {7'd0, irq_valid}, 8'd0);
    chk("R14 in_service in reset", {6'd0, in_service}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R14 idle");

    // R8 / R1: level-mode pin A
    ext_pin_n[0] = 1'b0; settle();
    chk("R8 level pin valid", {7'd0, irq_valid}, 8'd1);
    chk("R1 pin A vector", {4'd0, irq_vec}, 8'd0);
    adv("R8");
    ext_pin_n[0] = 1'b1; settle();
    chk("R8 level pin released", {7'd0, irq_valid}, 8'd0);
    adv("R8");

    // R2: disabled serial source
    periph_irq[8] = 1'b1; src_enable[14] = 1'b0; settle();
    chk("R2 disabled source", {7'd0, irq_valid}, 8'd0);
    adv("R2");
    // R3: global gate
    src_enable[14] = 1'b1; global_enable = 1'b0; settle();
    chk("R3 global off", {7'd0, irq_valid}, 8'd0);
    adv("R3");
    global_enable = 1'b1; settle();
    chk("R1 serial vector", {4'd0, irq_vec}, 8'd14);
    adv("R3");
    // R5 / R4
    periph_irq[6] = 1'b1; settle();
    chk("R5 lowest index wins", {4'd0, irq_vec}, 8'd12);
    adv("R5");
    src_high_prio[14] = 1'b1; settle();
    chk("R4 high beats low", {4'd0, irq_vec}, 8'd14);
    chk("R4 level flag", {7'd0, irq_high}, 8'd1);
    // R12: accept high
    irq_ready = 1'b1; adv("R12");
    irq_ready = 1'b0; settle();
    chk("R12 high in service", {6'd0, in_service}, 8'd2);
    // R7: second high blocked
    src_high_prio[12] = 1'b1; settle();
    chk("R7 high no nest", {7'd0, irq_valid}, 8'd0);
    adv("R7");
    src_high_prio[12] = 1'b0; settle();
    chk("R6 low no preempt", {7'd0, irq_valid}, 8'd0);
    reti_strobe = 1'b1; adv("R13");
    reti_strobe = 1'b0; periph_irq[8] = 1'b0; settle();
    chk("R13 return clears high", {6'd0, in_service}, 8'd0);
    // R6: low taken, then high preempts
    irq_ready = 1'b1; adv("R6");
    irq_ready = 1'b0; periph_irq[8] = 1'b1; settle();
    chk("R6 high preempts low", {4'd0, irq_vec}, 8'd14);
    irq_ready = 1'b1; adv("R6");
    irq_ready = 1'b0; periph_irq = '0; settle();
    chk("R12 both levels busy", {6'd0, in_service}, 8'd3);
    reti_strobe = 1'b1; adv("R13");
    settle();
    chk("R13 innermost first", {6'd0, in_service}, 8'd1);
    adv("R13");
    reti_strobe = 1'b0; settle();
    chk("R13 all returned", {6'd0, in_service}, 8'd0);
    src_high_prio = '0;

    // R9: edge mode on pin B
    ext_edge_mode[1] = 1'b1; cyc("R9");
    ext_pin_n[1] = 1'b0; settle();
    chk("R9 not before edge", {7'd0, irq_valid}, 8'd0);
    adv("R9");
    ext_pin_n[1] = 1'b1; settle();
    chk("R9 latched valid", {7'd0, irq_valid}, 8'd1);
    chk("R9 pin B vector", {4'd0, irq_vec}, 8'd2);
    irq_ready = 1'b1; adv("R9");
    irq_ready = 1'b0; reti_strobe = 1'b1; adv("R9");
    reti_strobe = 1'b0; settle();
    chk("R9 flag cleared by accept", {7'd0, irq_valid}, 8'd0);
    adv("R9");

    // R10: capture 2 falling only
    cap_fall_en[2] = 1'b1; cap_in[2] = 1'b1; cyc("R10");
    settle();
    chk("R10 rise ignored", {7'd0, irq_valid}, 8'd0);
    cap_in[2] = 1'b0; adv("R10");
    settle();
    chk("R10 fall caught", {4'd0, irq_vec}, 8'd6);
    chk("R10 fall valid", {7'd0, irq_valid}, 8'd1);
    irq_ready = 1'b1; adv("R10");
    irq_ready = 1'b0; reti_strobe = 1'b1; adv("R10");
    reti_strobe = 1'b0; settle();
    chk("R10 flag cleared", {7'd0, irq_valid}, 8'd0);
    adv("R10");

    // R11: DMA hold keeps pending
    dma_busy = 1'b1; ext_pin_n[1] = 1'b0; cyc("R11");
    ext_pin_n[1] = 1'b1; cyc("R11");
    settle();
    chk("R11 held during dma", {7'd0, irq_valid}, 8'd0);
    adv("R11");
    dma_busy = 1'b0; settle();
    chk("R11 served after dma", {4'd0, irq_vec}, 8'd2);
    irq_ready = 1'b1; adv("R11");
    irq_ready = 1'b0; reti_strobe = 1'b1; adv("R11");
    reti_strobe = 1'b0;

    // constrained random against the model
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 3) == 0) ext_pin_n = 2'($urandom);
      if ($urandom_range(0, 31) == 0) ext_edge_mode = 2'($urandom);
      if ($urandom_range(0, 2) == 0) cap_in = 4'($urandom);
      if ($urandom_range(0, 31) == 0) begin
        cap_rise_en = 4'($urandom); cap_fall_en = 4'($urandom);
      end
      if ($urandom_range(0, 3) == 0) periph_irq = 9'($urandom) & 9'($urandom);
      if ($urandom_range(0, 15) == 0) src_enable = 15'($urandom) | 15'($urandom);
      if ($urandom_range(0, 7) == 0) src_high_prio = 15'($urandom);
      global_enable = ($urandom_range(0, 15) != 0);
      dma_busy = ($urandom_range(0, 9) == 0);
      irq_ready = $urandom_range(0, 1) == 1;
      reti_strobe = ($urandom_range(0, 5) == 0);
      cyc("R5 random");
    end
    finish_run();
  end
endmodule